// File: doc/BRIEF.md
# Virtual-to-Physical Address Translator with Set-Indexed Lookaside Buffer

This block sits beside a processor load/store port and turns each virtual address into a physical address. The low page-offset bits pass straight through. The upper bits form the virtual page number. The page number is first looked up in a small two-way, set-indexed translation buffer. A hit answers on the next cycle and makes no memory access.

On a miss, a single-level table walker fetches one table entry over a plain read-request interface. The entry address is the per-process table base plus the page number scaled by the entry size. The walker then checks the presence and permission bits. It either returns the physical address or reports a fault with a two-bit cause. Only a successful walk writes the entry into the buffer. Permission bits are stored with every cached entry, so the same checks apply on a hit.

Requests use a valid/ready handshake, and only one translation is in flight at a time. A flush input invalidates every cached entry in a single cycle.

Top module: `xlt_mmu`

## Requirements
- R1: The physical address is the 12-bit physical page number placed above the untouched 12-bit page offset, so `rsp_paddr[11:0]` always equals `req_vaddr[11:0]` on a successful translation. A success reports `rsp_fault`=0 and `rsp_cause`=00.
- R2: On a miss, exactly one memory read is issued, at `mem_addr = pt_base + vpn*2`, where vpn is `req_vaddr[31:12]`. The 16-bit table entry is laid out as: bit0 present, bit1 read-allowed, bit2 write-allowed, bit3 supervisor-only, bits[15:4] physical page number. The response follows the cycle after `mem_rvalid`.
- R3: On a hit, `rsp_valid` rises on the clock edge after the request is accepted, and no memory read is made.
- R4: An entry whose present bit is 0 gives `rsp_fault`=1, `rsp_cause`=01 and `rsp_paddr`=0.
- R5: A read of a page without read-allowed, or a write to a page without write-allowed, faults with cause 10.
- R6: A user access (`req_user`=1) to a supervisor-only page faults with cause 11. This cause takes priority over cause 10.
- R7: The buffer set is vpn[1:0] and the stored tag is vpn[19:2]. A page number that shares a set but differs in its tag misses.
- R8: Each set holds two entries. A refill uses an empty way first; otherwise it replaces the way used least recently, where both hits and refills count as uses.
- R9: An entry that faults (absent or denied) is never written into the buffer, so a repeat of the same access walks again.
- R10: While `flush` is high, `req_ready` is low. After a one-cycle flush, every page misses.
- R11: While a walk is in progress, `req_ready` is low. `mem_req` stays high with `mem_addr` stable until `mem_rvalid` is seen.
- R12: After reset, `req_ready`=1, `mem_req`=0 and `rsp_valid`=0. Each response is a one-cycle `rsp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all buffer entries |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request can be accepted |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = store, 0 = load |
| req_user | input | 1 | 1 = user mode access |
| pt_base | input | 24 | Page table base (physical byte address) |
| mem_req | output | 1 | Table entry read request |
| mem_addr | output | 24 | Table entry address |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 16 | Table entry |
| rsp_valid | output | 1 | Response pulse |
| rsp_paddr | output | 24 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Translation failed |
| rsp_cause | output | 2 | 00 none, 01 absent, 10 access denied, 11 supervisor only |

## Verification
Several rules are checked on every cycle:
- a walk keeps `req_ready` low and holds its read request steady until the data arrives;
- every accepted request leads at once either to a response or to a walk;
- a returned entry always produces a response on the next cycle;
- a fault never carries an address, and a success never carries a cause.

Other behaviours depend on history, and only the bench's scenarios can show them: the cause priority, the refusal to cache faulting entries, LRU victim choice within a set, tag mismatch in a shared set, and the effect of a flush. The bench shows them by counting memory reads for each access and comparing the returned addresses against its own page table.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  // Fault causes; the bit values are visible on rsp_cause.
  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'b00,
    CAUSE_ABSENT = 2'b01,
    CAUSE_RW     = 2'b10,
    CAUSE_PRIV   = 2'b11
  } cause_e;

  // Table entry flag positions; the page number starts at PTE_PPN_LSB.
  localparam int PTE_V       = 0;
  localparam int PTE_R       = 1;
  localparam int PTE_W       = 2;
  localparam int PTE_S       = 3;
  localparam int PTE_PPN_LSB = 4;

  typedef struct packed {
    logic sup;
    logic wr;
    logic rd;
  } perm_t;
endpackage

// File: rtl/xlt_perm.sv
module xlt_perm
  import xlt_pkg::*;
(
  input  logic   present,
  input  perm_t  perm,
  input  logic   is_write,
  input  logic   is_user,
  output logic   fault,
  output cause_e cause
);
  // Priority: absent, then privilege, then read/write right.
  always_comb begin
    if (!present)                               cause = CAUSE_ABSENT;
    else if (is_user && perm.sup)               cause = CAUSE_PRIV;
    else if (is_write ? !perm.wr : !perm.rd)    cause = CAUSE_RW;
    else                                        cause = CAUSE_NONE;
    fault = (cause != CAUSE_NONE);
  end
endmodule

// File: rtl/xlt_tlb.sv
module xlt_tlb
  import xlt_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int PPN_W = 12,
  parameter int SETS  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  output perm_t            lk_perm,
  input  logic             touch,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  perm_t            fill_perm
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int WAYS  = 2;

  logic [WAYS-1:0]  vld_q [SETS];
  logic             lru_q [SETS];   // way to replace next
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [PPN_W-1:0] ppn_q [SETS][WAYS];
  perm_t            prm_q [SETS][WAYS];

  logic [IDX_W-1:0] lk_idx, fill_idx;
  logic [TAG_W-1:0] lk_tag;
  logic [WAYS-1:0]  way_hit;
  logic             hit_way, victim;

  assign lk_idx   = lk_vpn[IDX_W-1:0];
  assign lk_tag   = lk_vpn[VPN_W-1:IDX_W];
  assign fill_idx = fill_vpn[IDX_W-1:0];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign way_hit[w] = vld_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
  end

  assign lk_hit  = |way_hit;
  assign hit_way = way_hit[1];
  assign lk_ppn  = ppn_q[lk_idx][hit_way];
  assign lk_perm = prm_q[lk_idx][hit_way];

  // Empty way first, otherwise the least recently used one.
  always_comb begin
    if (!vld_q[fill_idx][0])      victim = 1'b0;
    else if (!vld_q[fill_idx][1]) victim = 1'b1;
    else                          victim = lru_q[fill_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        lru_q[s] <= 1'b0;
      end
    end else begin
      if (flush) begin
        for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
      end else if (fill_en) begin
        vld_q[fill_idx][victim] <= 1'b1;
      end
      if (fill_en)    lru_q[fill_idx] <= ~victim;
      else if (touch) lru_q[lk_idx]   <= ~hit_way;
    end
  end

  // Payload needs no reset: it is qualified by the valid bits.
  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_idx][victim] <= fill_vpn[VPN_W-1:IDX_W];
      ppn_q[fill_idx][victim] <= fill_ppn;
      prm_q[fill_idx][victim] <= fill_perm;
    end
  end
endmodule

// File: rtl/xlt_walk.sv
module xlt_walk #(
  parameter int VA_W   = 32,
  parameter int PA_W   = 24,
  parameter int OFF_W  = 12,
  parameter int PTE_DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VA_W-1:0]   start_va,
  input  logic              start_wr,
  input  logic              start_usr,
  input  logic [PA_W-1:0]   base,
  output logic              busy,
  output logic              mem_req,
  output logic [PA_W-1:0]   mem_addr,
  input  logic              mem_rvalid,
  input  logic [PTE_DW-1:0] mem_rdata,
  output logic              done,
  output logic [PTE_DW-1:0] pte,
  output logic [VA_W-1:0]   va_q,
  output logic              wr_q,
  output logic              usr_q
);
  localparam int VPN_W     = VA_W - OFF_W;
  localparam int PTE_SHIFT = $clog2(PTE_DW / 8);

  typedef enum logic {W_IDLE, W_FETCH} wstate_e;
  wstate_e          st_q, st_d;
  logic [PA_W-1:0]  base_q;
  logic [VPN_W-1:0] vpn;

  assign vpn      = va_q[VA_W-1:OFF_W];
  assign busy     = (st_q == W_FETCH);
  assign mem_req  = busy;
  assign mem_addr = base_q + PA_W'({vpn, {PTE_SHIFT{1'b0}}});
  assign done     = busy && mem_rvalid;
  assign pte      = mem_rdata;

  always_comb begin
    st_d = st_q;
    case (st_q)
      W_IDLE:  if (start) st_d = W_FETCH;
      W_FETCH: if (mem_rvalid) st_d = W_IDLE;
      default: st_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= W_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (start) begin
      va_q   <= start_va;
      wr_q   <= start_wr;
      usr_q  <= start_usr;
      base_q <= base;
    end
  end
endmodule

// File: rtl/xlt_mmu.sv
module xlt_mmu
  import xlt_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int PA_W     = 24,
  parameter int OFF_W    = 12,
  parameter int TLB_SETS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  input  logic             req_user,
  input  logic [PA_W-1:0]  pt_base,
  output logic             mem_req,
  output logic [PA_W-1:0]  mem_addr,
  input  logic             mem_rvalid,
  input  logic [15:0]      mem_rdata,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_fault,
  output logic [1:0]       rsp_cause
);
  localparam int VPN_W  = VA_W - OFF_W;
  localparam int PPN_W  = PA_W - OFF_W;
  localparam int PTE_DW = PTE_PPN_LSB + PPN_W;

  logic             busy, accept, lk_hit, walk_done, start;
  logic [PPN_W-1:0] lk_ppn, chk_ppn;
  perm_t            lk_perm, chk_perm, pte_perm;
  logic [PTE_DW-1:0] pte;
  logic [VA_W-1:0]  va_q;
  logic             wr_q, usr_q;
  logic             chk_present, chk_wr, chk_usr, chk_fault;
  logic [OFF_W-1:0] chk_off;
  cause_e           chk_cause;
  logic             rsp_fire;

  logic             rsp_valid_q, rsp_valid_d, rsp_fault_q, rsp_fault_d;
  logic [PA_W-1:0]  rsp_paddr_q, rsp_paddr_d;
  cause_e           rsp_cause_q, rsp_cause_d;

  assign req_ready = !busy && !flush;
  assign accept    = req_valid && req_ready;
  assign start     = accept && !lk_hit;
  assign pte_perm  = '{sup: pte[PTE_S], wr: pte[PTE_W], rd: pte[PTE_R]};

  xlt_tlb #(.VPN_W(VPN_W), .PPN_W(PPN_W), .SETS(TLB_SETS)) tlb_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_vpn(req_vaddr[VA_W-1:OFF_W]), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
    .lk_perm(lk_perm), .touch(accept && lk_hit),
    .fill_en(walk_done && !chk_fault), .fill_vpn(va_q[VA_W-1:OFF_W]),
    .fill_ppn(pte[PTE_PPN_LSB +: PPN_W]), .fill_perm(pte_perm)
  );

  xlt_walk #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .PTE_DW(PTE_DW)) walk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_va(req_vaddr),
    .start_wr(req_write), .start_usr(req_user), .base(pt_base),
    .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .done(walk_done),
    .pte(pte), .va_q(va_q), .wr_q(wr_q), .usr_q(usr_q)
  );

  // One checker shared by the hit path and the walk-return path.
  always_comb begin
    if (walk_done) begin
      chk_present = pte[PTE_V];
      chk_perm    = pte_perm;
      chk_wr      = wr_q;
      chk_usr     = usr_q;
      chk_ppn     = pte[PTE_PPN_LSB +: PPN_W];
      chk_off     = va_q[OFF_W-1:0];
    end else begin
      chk_present = 1'b1;
      chk_perm    = lk_perm;
      chk_wr      = req_write;
      chk_usr     = req_user;
      chk_ppn     = lk_ppn;
      chk_off     = req_vaddr[OFF_W-1:0];
    end
  end

  xlt_perm perm_i (
    .present(chk_present), .perm(chk_perm), .is_write(chk_wr),
    .is_user(chk_usr), .fault(chk_fault), .cause(chk_cause)
  );

  assign rsp_fire = walk_done || (accept && lk_hit);

  always_comb begin
    rsp_valid_d = rsp_fire;
    rsp_fault_d = rsp_fault_q;
    rsp_cause_d = rsp_cause_q;
    rsp_paddr_d = rsp_paddr_q;
    if (rsp_fire) begin
      rsp_fault_d = chk_fault;
      rsp_cause_d = chk_cause;
      rsp_paddr_d = chk_fault ? '0 : {chk_ppn, chk_off};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_fault_q <= 1'b0;
      rsp_cause_q <= CAUSE_NONE;
      rsp_paddr_q <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rsp_fault_q <= rsp_fault_d;
      rsp_cause_q <= rsp_cause_d;
      rsp_paddr_q <= rsp_paddr_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_fault = rsp_fault_q;
  assign rsp_cause = rsp_cause_q;
  assign rsp_paddr = rsp_paddr_q;
endmodule

// File: rtl/xlt_mmu_chk.sv
module xlt_mmu_chk #(
  parameter int PA_W = 24
) (
  input logic            clk,
  input logic            rst_n,
  input logic            flush,
  input logic            req_valid,
  input logic            req_ready,
  input logic            mem_req,
  input logic [PA_W-1:0] mem_addr,
  input logic            mem_rvalid,
  input logic            rsp_valid,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            rsp_fault,
  input logic [1:0]      rsp_cause
);
  assert_ready_low_walk_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);

  assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));

  assert_flush_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !req_ready);

  assert_accept_progress_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid || mem_req);

  assert_fetch_answers_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_rvalid |=> rsp_valid);

  assert_fault_no_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_paddr == '0 && rsp_cause != 2'b00);

  assert_ok_no_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_cause == 2'b00);
endmodule

bind xlt_mmu xlt_mmu_chk #(.PA_W(PA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
  .req_ready(req_ready), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_rvalid(mem_rvalid), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
  .rsp_fault(rsp_fault), .rsp_cause(rsp_cause)
);

// File: tb/xlt_mmu_tb_top.sv
`timescale 1ns/1ps
module xlt_mmu_tb_top;
  localparam logic [23:0] BASE = 24'h010000;

  logic        clk, rst_n, flush, req_valid, req_ready, req_write, req_user;
  logic [31:0] req_vaddr;
  logic [23:0] pt_base, mem_addr, rsp_paddr;
  logic        mem_req, mem_rvalid, rsp_valid, rsp_fault;
  logic [15:0] mem_rdata;
  logic [1:0]  rsp_cause;

  xlt_mmu dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
    .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
    .req_user(req_user), .pt_base(pt_base), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .rsp_cause(rsp_cause)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0, n_reads = 0;
  logic [23:0] last_addr;
  logic [15:0] pt [64];

  // Entry: bit0 present, bit1 read, bit2 write, bit3 supervisor, [15:4] ppn
  function automatic logic [15:0] mk(input logic [11:0] ppn, input logic s, w, r, v);
    return {ppn, s, w, r, v};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // Memory model: answers two cycles after a request appears.
  initial begin
    int lat;
    int idx;
    lat = 0;
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
    forever begin
      @(negedge clk);
      if (mem_req && !mem_rvalid) begin
        if (lat == 1) begin
          idx = int'((mem_addr - BASE) >> 1);
          mem_rdata  = (idx >= 0 && idx < 64) ? pt[idx] : 16'h0000;
          mem_rvalid = 1'b1;
          last_addr  = mem_addr;
          n_reads++;
          lat = 0;
        end else lat++;
      end else mem_rvalid = 1'b0;
    end
  end

  logic        g_fault;
  logic [1:0]  g_cause;
  logic [23:0] g_pa;
  int          g_reads, g_wait;
  bit          g_ready_bad;

  task automatic xlate(input logic [31:0] va, input logic wr, input logic usr);
    int r0;
    @(negedge clk);
    req_vaddr = va; req_write = wr; req_user = usr; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    r0 = n_reads;
    @(negedge clk);
    req_valid = 1'b0;
    g_wait = 0;
    g_ready_bad = 0;
    while (!rsp_valid && g_wait < 40) begin
      if (mem_req && req_ready) g_ready_bad = 1;
      @(negedge clk);
      g_wait++;
    end
    chk(rsp_valid, "R11", "response timeout", 32'(rsp_valid), 32'd1);
    g_fault = rsp_fault; g_cause = rsp_cause; g_pa = rsp_paddr;
    g_reads = n_reads - r0;
  endtask

  // {va, write, user, fault, cause, paddr, reads}
  localparam int NV = 16;
  localparam logic [62:0] VEC [NV] = '{
    {32'h00001234, 1'b0, 1'b1, 1'b0, 2'b00, 24'h0A5234, 2'd1},
    {32'h00001ABC, 1'b1, 1'b1, 1'b0, 2'b00, 24'h0A5ABC, 2'd0},
    {32'h00002010, 1'b0, 1'b1, 1'b0, 2'b00, 24'h123010, 2'd1},
    {32'h00002010, 1'b1, 1'b1, 1'b1, 2'b10, 24'h000000, 2'd0},
    {32'h00003000, 1'b0, 1'b1, 1'b1, 2'b11, 24'h000000, 2'd1},
    {32'h00003FFF, 1'b0, 1'b0, 1'b0, 2'b00, 24'h456FFF, 2'd1},
    {32'h00003000, 1'b1, 1'b0, 1'b0, 2'b00, 24'h456000, 2'd0},
    {32'h00004000, 1'b0, 1'b1, 1'b1, 2'b01, 24'h000000, 2'd1},
    {32'h00004000, 1'b0, 1'b1, 1'b1, 2'b01, 24'h000000, 2'd1},
    {32'h00005000, 1'b0, 1'b1, 1'b1, 2'b10, 24'h000000, 2'd1},
    {32'h00005008, 1'b1, 1'b1, 1'b0, 2'b00, 24'h777008, 2'd1},
    {32'h00001000, 1'b0, 1'b1, 1'b0, 2'b00, 24'h0A5000, 2'd0},
    {32'h00009000, 1'b0, 1'b1, 1'b0, 2'b00, 24'h999000, 2'd1},
    {32'h00001000, 1'b0, 1'b1, 1'b0, 2'b00, 24'h0A5000, 2'd0},
    {32'h00005004, 1'b1, 1'b1, 1'b0, 2'b00, 24'h777004, 2'd1},
    {32'h00401234, 1'b0, 1'b1, 1'b1, 2'b01, 24'h000000, 2'd1}
  };
  localparam string VTAG [NV] = '{"R1", "R3", "R1", "R5", "R6", "R9", "R3", "R4",
                                  "R9", "R5", "R5", "R3", "R8", "R8", "R8", "R7"};

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R11 watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) pt[i] = 16'h0000;
    pt[1] = mk(12'h0A5, 1'b0, 1'b1, 1'b1, 1'b1);
    pt[2] = mk(12'h123, 1'b0, 1'b0, 1'b1, 1'b1);
    pt[3] = mk(12'h456, 1'b1, 1'b1, 1'b1, 1'b1);
    pt[5] = mk(12'h777, 1'b0, 1'b1, 1'b0, 1'b1);
    pt[6] = mk(12'h666, 1'b1, 1'b0, 1'b1, 1'b1);
    pt[9] = mk(12'h999, 1'b0, 1'b1, 1'b1, 1'b1);
    rst_n = 1'b0; flush = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_user = 1'b0; req_vaddr = '0; pt_base = BASE;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(req_ready == 1'b1, "R12", "ready after reset", 32'(req_ready), 32'd1);
    chk(rsp_valid == 1'b0, "R12", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk(mem_req == 1'b0, "R12", "mem_req after reset", 32'(mem_req), 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] va;
      logic [23:0] ea;
      va = VEC[i][62:31];
      xlate(va, VEC[i][30], VEC[i][29]);
      chk(g_fault == VEC[i][28], VTAG[i], $sformatf("vec%0d fault", i), 32'(g_fault), 32'(VEC[i][28]));
      chk(g_cause == VEC[i][27:26], VTAG[i], $sformatf("vec%0d cause", i), 32'(g_cause), 32'(VEC[i][27:26]));
      chk(g_pa == VEC[i][25:2], "R1", $sformatf("vec%0d paddr", i), 32'(g_pa), 32'(VEC[i][25:2]));
      chk(g_reads == int'(VEC[i][1:0]), VEC[i][1:0] == 0 ? "R3" : "R2",
          $sformatf("vec%0d reads", i), 32'(g_reads), 32'(VEC[i][1:0]));
      if (VEC[i][1:0] == 0)
        chk(g_wait == 0, "R3", $sformatf("vec%0d hit latency", i), 32'(g_wait), 32'd0);
      else begin
        ea = BASE + {3'b0, va[31:12], 1'b0};
        chk(last_addr == ea, "R2", $sformatf("vec%0d entry addr", i), 32'(last_addr), 32'(ea));
        chk(!g_ready_bad, "R11", $sformatf("vec%0d ready during walk", i), 32'(g_ready_bad), 32'd0);
      end
    end

    // R12: response is a single-cycle pulse
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R12", "pulse width", 32'(rsp_valid), 32'd0);

    // R6: supervisor cause wins over access-denied (user write to read-only sup page)
    xlate(32'h00006000, 1'b1, 1'b1);
    chk(g_cause == 2'b11, "R6", "cause priority", 32'(g_cause), 32'h3);

    // R8: vpn 9 was evicted by vpn 5, so it walks again; vpn 5 stays resident
    xlate(32'h00009010, 1'b0, 1'b1);
    chk(g_reads == 1, "R8", "evicted page refetched", 32'(g_reads), 32'd1);
    chk(g_pa == 24'h999010, "R8", "refetched paddr", 32'(g_pa), 32'h999010);
    xlate(32'h00005000, 1'b1, 1'b1);
    chk(g_reads == 0, "R8", "recent way kept", 32'(g_reads), 32'd0);

    // R10: flush blocks requests and empties the buffer
    @(negedge clk);
    flush = 1'b1;
    #1;
    chk(req_ready == 1'b0, "R10", "ready during flush", 32'(req_ready), 32'd0);
    @(negedge clk);
    flush = 1'b0;
    xlate(32'h00005000, 1'b1, 1'b1);
    chk(g_reads == 1, "R10", "miss after flush", 32'(g_reads), 32'd1);
    chk(g_pa == 24'h777000, "R10", "paddr after flush", 32'(g_pa), 32'h777000);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule